// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

This block gathers up to 64 level-sensitive peripheral interrupt requests, grouped into banks of 32, and presents them to a processor as two request lines: a normal interrupt line and a fast interrupt line. Software reaches the controller through a simple word-wide read/write port. Per bank, it can see which sources are active, enable or block each one, and choose whether each one drives the normal or the fast line.

Each source input passes through one register stage. A table of priority slots, one per source, sets the service order. Each slot names a source and carries a valid flag, and a lower slot index wins. The controller continuously finds the highest-ranked slot whose named source is active, enabled and routed to the normal line. It reports that source through a dedicated register, so a handler can read the next source without scanning bits itself.

A third output, the wake indication, tells a power controller that an interrupt wants the core out of idle. One control bit chooses between two cases. Either any active source wakes the core, or only enabled sources do.

Top module: `banked_intc`

## Requirements
- R1: After reset, irq_o, fiq_o and wake_o are low. Every mask, routing and control register reads 0, every priority slot reads 0 (invalid), and the winner register (offset 0x18) reads 0 with bit 31 clear.
- R2: Mask and routing registers read back all 32 bits as written. A slot register reads back only bit 31 (valid) and bits 5:0 (source number), with all other bits 0. The control register (offset 0x14) reads back only bit 0.
- R3: The raw pending register (bank offset 0x10) shows the source inputs as captured by one register stage. Writes to the pending registers (offsets 0x00, 0x0C, 0x10) and to the winner register (0x18) have no effect.
- R4: The IRQ pending register (offset 0x00) shows active sources whose routing bit is 0. The FIQ pending register (offset 0x0C) shows active sources whose routing bit is 1. Neither depends on the mask.
- R5: irq_o is high when some active source has its mask bit at 1 and its routing bit at 0. fiq_o is high when some such source has its routing bit at 1. Each is registered, so a source input change reaches it at the second rising edge after the input is driven.
- R6: The winner register holds bit 31 = 1 and bits 30:16 = source number when some valid slot names a source that is active, unmasked and routed to IRQ. The lowest such slot index wins. Otherwise the register reads 0.
- R7: wake_o is registered. With control bit 0 at 1 it is high when some active source has its mask bit at 1. With control bit 0 at 0 it is high when any source is active.
- R8: Bank 0 registers sit at offsets 0x00 to 0x18. Bank 1 repeats the IRQ pending, mask, routing, FIQ pending and raw pending registers at 0x9C + the same offsets. Slot s sits at 0x1C + 4*s for s < 32 and at 0xB0 + 4*(s-32) otherwise.
- R9: A read of an unmapped or non-word-aligned address returns 0. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive source requests |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; rd_data updates at the next edge |
| addr | input | 9 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake-from-idle indication |

## Verification
A mask write and a change on the source inputs can land in the same clock cycle, and both feed the winner search and the request lines at the same time. The bench provokes this by driving a new bank 0 mask and a new source pattern on the same edge. It then judges the winner register and irq_o against a model that applies both new values together. A winner whose slot sits below a higher-numbered source shows that slot order, not source number, decides the result.

// File: rtl/banked_intc_pkg.sv
package banked_intc_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 9;
    localparam int BANK_W   = 32;
    localparam int HP_SRC_W = 15;

    localparam logic [ADDR_W-1:0] OFS_IRQ_PEND = 9'h000;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 9'h004;
    localparam logic [ADDR_W-1:0] OFS_ROUTE    = 9'h008;
    localparam logic [ADDR_W-1:0] OFS_FIQ_PEND = 9'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW      = 9'h010;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 9'h014;
    localparam logic [ADDR_W-1:0] OFS_WINNER   = 9'h018;
    localparam logic [ADDR_W-1:0] SLOT_LO_BASE = 9'h01C;
    localparam logic [ADDR_W-1:0] BANK1_BASE   = 9'h09C;
    localparam logic [ADDR_W-1:0] SLOT_HI_BASE = 9'h0B0;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_IRQ_PEND,
        RK_MASK,
        RK_ROUTE,
        RK_FIQ_PEND,
        RK_RAW,
        RK_CTRL,
        RK_WINNER,
        RK_SLOT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic       bank;
        logic [5:0] slot;
    } reg_sel_t;

    function automatic reg_kind_e bank_kind(input logic [ADDR_W-1:0] ofs);
        reg_kind_e k;
        case (ofs)
            OFS_IRQ_PEND: k = RK_IRQ_PEND;
            OFS_MASK:     k = RK_MASK;
            OFS_ROUTE:    k = RK_ROUTE;
            OFS_FIQ_PEND: k = RK_FIQ_PEND;
            OFS_RAW:      k = RK_RAW;
            default:      k = RK_NONE;
        endcase
        return k;
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int num_banks,
                                             input int num_slots);
        reg_sel_t r;
        int       ai;
        int       rel;
        r.kind = RK_NONE;
        r.bank = 1'b0;
        r.slot = '0;
        ai     = int'(a);
        rel    = 0;
        if (a[1:0] == 2'b00) begin
            if (ai < int'(SLOT_LO_BASE)) begin
                if (a == OFS_CTRL)        r.kind = RK_CTRL;
                else if (a == OFS_WINNER) r.kind = RK_WINNER;
                else                      r.kind = bank_kind(a);
            end else if (ai < int'(BANK1_BASE)) begin
                rel = (ai - int'(SLOT_LO_BASE)) >> 2;
                if (rel < num_slots) begin
                    r.kind = RK_SLOT;
                    r.slot = 6'(rel);
                end
            end else if (ai < int'(SLOT_HI_BASE)) begin
                if (num_banks > 1) begin
                    r.kind = bank_kind(a - BANK1_BASE);
                    r.bank = 1'b1;
                end
            end else begin
                rel = 32 + ((ai - int'(SLOT_HI_BASE)) >> 2);
                if (rel < num_slots) begin
                    r.kind = RK_SLOT;
                    r.slot = 6'(rel);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/bintc_regs.sv
module bintc_regs
    import banked_intc_pkg::*;
#(
    parameter  int NUM_SRC   = 64,
    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W,
    localparam int PAD_W     = NUM_BANKS * BANK_W,
    localparam int SRC_W     = $clog2(NUM_SRC)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic [NUM_SRC-1:0]                src_q,
    input  logic                              hp_valid,
    input  logic [SRC_W-1:0]                  hp_src,
    output logic [NUM_SRC-1:0]                mask_o,
    output logic [NUM_SRC-1:0]                route_o,
    output logic                              ctrl_idle_o,
    output logic [NUM_SRC-1:0]                slot_valid_o,
    output logic [NUM_SRC-1:0][SRC_W-1:0]     slot_src_o,
    output logic [WORD_W-1:0]                 rd_data_o
);

    reg_sel_t             sel;
    logic [PAD_W-1:0]     mask_q;
    logic [PAD_W-1:0]     route_q;
    logic [PAD_W-1:0]     src_pad;
    logic                 ctrl_q;
    logic [WORD_W-1:0]    rd_next;
    logic [WORD_W-1:0]    rd_q;

    assign sel     = decode_addr(addr, NUM_BANKS, NUM_SRC);
    assign src_pad = PAD_W'(src_q);

    // per-bank mask and routing storage
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[b*BANK_W +: BANK_W]  <= '0;
                route_q[b*BANK_W +: BANK_W] <= '0;
            end else if (wr_en && int'(sel.bank) == b) begin
                if (sel.kind == RK_MASK)
                    mask_q[b*BANK_W +: BANK_W] <= wr_data;
                if (sel.kind == RK_ROUTE)
                    route_q[b*BANK_W +: BANK_W] <= wr_data;
            end
        end
    end

    // priority slot table
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_valid_o[s] <= 1'b0;
                slot_src_o[s]   <= '0;
            end else if (wr_en && sel.kind == RK_SLOT && int'(sel.slot) == s) begin
                slot_valid_o[s] <= wr_data[WORD_W-1];
                slot_src_o[s]   <= wr_data[SRC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= 1'b0;
        else if (wr_en && sel.kind == RK_CTRL)
            ctrl_q <= wr_data[0];
    end

    always_comb begin
        rd_next = '0;
        unique case (sel.kind)
            RK_IRQ_PEND: rd_next = src_pad[int'(sel.bank)*BANK_W +: BANK_W]
                                 & ~route_q[int'(sel.bank)*BANK_W +: BANK_W];
            RK_FIQ_PEND: rd_next = src_pad[int'(sel.bank)*BANK_W +: BANK_W]
                                 & route_q[int'(sel.bank)*BANK_W +: BANK_W];
            RK_RAW:      rd_next = src_pad[int'(sel.bank)*BANK_W +: BANK_W];
            RK_MASK:     rd_next = mask_q[int'(sel.bank)*BANK_W +: BANK_W];
            RK_ROUTE:    rd_next = route_q[int'(sel.bank)*BANK_W +: BANK_W];
            RK_CTRL:     rd_next = {{(WORD_W-1){1'b0}}, ctrl_q};
            RK_WINNER:   rd_next = {hp_valid, {(HP_SRC_W-SRC_W){1'b0}}, hp_src, 16'h0000};
            RK_SLOT:     rd_next = {slot_valid_o[sel.slot], {(WORD_W-1-SRC_W){1'b0}},
                                    slot_src_o[sel.slot]};
            RK_NONE:     rd_next = '0;
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= rd_next;
    end

    assign mask_o      = mask_q[NUM_SRC-1:0];
    assign route_o     = route_q[NUM_SRC-1:0];
    assign ctrl_idle_o = ctrl_q;
    assign rd_data_o   = rd_q;

endmodule

// File: rtl/bintc_prio.sv
module bintc_prio #(
    parameter  int NUM_SRC = 64,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             eligible,
    input  logic [NUM_SRC-1:0]             slot_valid,
    input  logic [NUM_SRC-1:0][SRC_W-1:0]  slot_src,
    output logic                           hit_o,
    output logic [SRC_W-1:0]               win_o
);

    // walk from the weakest slot up so the lowest index overrides last
    always_comb begin
        hit_o = 1'b0;
        win_o = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (slot_valid[s] && (int'(slot_src[s]) < NUM_SRC) && eligible[slot_src[s]]) begin
                hit_o = 1'b1;
                win_o = slot_src[s];
            end
        end
    end

endmodule

// File: rtl/bintc_outs.sv
module bintc_outs #(
    parameter  int NUM_SRC = 64,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_q,
    input  logic [NUM_SRC-1:0]   mask,
    input  logic [NUM_SRC-1:0]   route,
    input  logic                 ctrl_idle,
    input  logic                 hit,
    input  logic [SRC_W-1:0]     win,
    output logic [NUM_SRC-1:0]   eligible_o,
    output logic                 irq_o,
    output logic                 fiq_o,
    output logic                 wake_o,
    output logic                 hp_valid_o,
    output logic [SRC_W-1:0]     hp_src_o
);

    logic [NUM_SRC-1:0] enabled;
    logic               wake_next;

    assign enabled    = src_q & mask;
    assign eligible_o = enabled & ~route;
    assign wake_next  = ctrl_idle ? (|enabled) : (|src_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o      <= 1'b0;
            fiq_o      <= 1'b0;
            wake_o     <= 1'b0;
            hp_valid_o <= 1'b0;
            hp_src_o   <= '0;
        end else begin
            irq_o      <= |eligible_o;
            fiq_o      <= |(enabled & route);
            wake_o     <= wake_next;
            hp_valid_o <= hit;
            hp_src_o   <= hit ? win : '0;
        end
    end

endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import banked_intc_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wr_data,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  irq_o,
    output logic                  fiq_o,
    output logic                  wake_o
);

    logic [NUM_SRC-1:0]             src_q;
    logic [NUM_SRC-1:0]             mask_w;
    logic [NUM_SRC-1:0]             route_w;
    logic                           ctrl_idle_w;
    logic [NUM_SRC-1:0]             slot_valid_w;
    logic [NUM_SRC-1:0][SRC_W-1:0]  slot_src_w;
    logic [NUM_SRC-1:0]             elig_w;
    logic                           hit_w;
    logic [SRC_W-1:0]               win_w;
    logic                           hp_valid_w;
    logic [SRC_W-1:0]               hp_src_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            src_q <= '0;
        else
            src_q <= src_i;
    end

    bintc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .src_q        (src_q),
        .hp_valid     (hp_valid_w),
        .hp_src       (hp_src_w),
        .mask_o       (mask_w),
        .route_o      (route_w),
        .ctrl_idle_o  (ctrl_idle_w),
        .slot_valid_o (slot_valid_w),
        .slot_src_o   (slot_src_w),
        .rd_data_o    (rd_data)
    );

    bintc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .eligible   (elig_w),
        .slot_valid (slot_valid_w),
        .slot_src   (slot_src_w),
        .hit_o      (hit_w),
        .win_o      (win_w)
    );

    bintc_outs #(.NUM_SRC(NUM_SRC)) u_outs (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_q      (src_q),
        .mask       (mask_w),
        .route      (route_w),
        .ctrl_idle  (ctrl_idle_w),
        .hit        (hit_w),
        .win        (win_w),
        .eligible_o (elig_w),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o),
        .wake_o     (wake_o),
        .hp_valid_o (hp_valid_w),
        .hp_src_o   (hp_src_w)
    );

endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk #(
    parameter int NUM_SRC = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  src_i,
    input logic [NUM_SRC-1:0]  src_q,
    input logic [NUM_SRC-1:0]  mask,
    input logic [NUM_SRC-1:0]  route,
    input logic                ctrl_idle,
    input logic                wr_en,
    input logic [8:0]          addr,
    input logic [31:0]         wr_data,
    input logic                irq_o,
    input logic                fiq_o,
    input logic                wake_o,
    input logic                hp_valid
);

    logic warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst_n)
        !irq_o && !fiq_o && !wake_o && !hp_valid);

    a_r3_raw_capture: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> src_q == $past(src_i));

    a_r5_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> irq_o == $past(|(src_q & mask & ~route)));

    a_r5_fiq_line: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> fiq_o == $past(|(src_q & mask & route)));

    a_r6_winner_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |-> irq_o);

    a_r7_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(ctrl_idle)) |-> wake_o == $past(|(src_q & mask)));

    a_r7_wake_any: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(ctrl_idle)) |-> wake_o == $past(|src_q));

    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(wr_en && addr == 9'h004)) |-> mask[31:0] == $past(wr_data));

endmodule

bind banked_intc banked_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .src_q     (src_q),
    .mask      (mask_w),
    .route     (route_w),
    .ctrl_idle (ctrl_idle_w),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .wake_o    (wake_o),
    .hp_valid  (hp_valid_w)
);

// File: tb/test_banked_intc.sv
`timescale 1ns/1ps
module test_banked_intc;

    localparam logic [63:0] LVL = 64'hA5A5_0F0F_3C3C_F00F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src;
    logic        wr_en;
    logic        rd_en;
    logic [8:0]  addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq_o;
    logic        fiq_o;
    logic        wake_o;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] m_mask;
    logic [63:0] m_route;
    logic        m_ctrl;
    logic        m_sv [64];
    logic [5:0]  m_ss [64];

    always #2 clk = ~clk;

    banked_intc i_banked_intc (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o),
        .wake_o  (wake_o)
    );

    function automatic logic [8:0] bank_base(input int b);
        return (b != 0) ? 9'h09C : 9'h000;
    endfunction

    function automatic logic [8:0] slot_addr(input int s);
        return (s < 32) ? 9'(9'h01C + 4*s) : 9'(9'h0B0 + 4*(s-32));
    endfunction

    function automatic logic [63:0] xs(input logic [63:0] v);
        v = v ^ (v << 13);
        v = v ^ (v >> 7);
        v = v ^ (v << 17);
        return v;
    endfunction

    function automatic logic [31:0] exp_winner(input logic [63:0] s);
        logic [63:0] e;
        e = s & m_mask & ~m_route;
        for (int k = 0; k < 64; k++)
            if (m_sv[k] && e[m_ss[k]])
                return {1'b1, 9'd0, m_ss[k], 16'h0000};
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mask(input logic [63:0] v);
        wr(9'h004, v[31:0]);
        wr(9'h09C + 9'h004, v[63:32]);
        m_mask = v;
    endtask

    task automatic set_route(input logic [63:0] v);
        wr(9'h008, v[31:0]);
        wr(9'h09C + 9'h008, v[63:32]);
        m_route = v;
    endtask

    task automatic set_ctrl(input logic v);
        wr(9'h014, {31'd0, v});
        m_ctrl = v;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] x;
        rst_n = 1'b0; src = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        m_mask = '0; m_route = '0; m_ctrl = 1'b0;
        for (int k = 0; k < 64; k++) begin m_sv[k] = 1'b0; m_ss[k] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
        chk("R1 wake_o", {31'd0, wake_o}, 32'd0);
        rd(9'h018, d); chk("R1 winner", d, 32'd0);
        rd(9'h004, d); chk("R1 mask bank0", d, 32'd0);
        rd(9'h0A0, d); chk("R1 mask bank1", d, 32'd0);
        rd(9'h0A4, d); chk("R1 route bank1", d, 32'd0);
        rd(9'h014, d); chk("R1 ctrl", d, 32'd0);
        rd(slot_addr(0), d);  chk("R1 slot0", d, 32'd0);
        rd(slot_addr(63), d); chk("R1 slot63", d, 32'd0);

        // R2 and R8 readback formats and placement
        wr(slot_addr(5), 32'hFFFF_FFFF);
        rd(slot_addr(5), d); chk("R2 slot format", d, 32'h8000_003F);
        wr(9'h098, 32'h0000_0015);
        rd(9'h098, d); chk("R8 slot31 address", d, 32'h0000_0015);
        wr(9'h0D0, 32'h8000_0022);
        rd(9'h0D0, d); chk("R8 slot40 address", d, 32'h8000_0022);
        rd(slot_addr(40), d); chk("R8 slot40 via map", d, 32'h8000_0022);
        wr(9'h014, 32'hFFFF_FFFE);
        rd(9'h014, d); chk("R2 ctrl bit0 clear", d, 32'd0);
        wr(9'h014, 32'hFFFF_FFFF);
        rd(9'h014, d); chk("R2 ctrl bit0 only", d, 32'd1);
        set_ctrl(1'b0);
        wr(9'h0A0, 32'h1234_5678);
        rd(9'h0A0, d); chk("R2 mask bank1", d, 32'h1234_5678);
        rd(9'h004, d); chk("R8 bank0 mask untouched", d, 32'd0);
        wr(9'h008, 32'hCAFE_F00D);
        rd(9'h008, d); chk("R2 route bank0", d, 32'hCAFE_F00D);

        // R9 unmapped and misaligned
        wr(9'h130, 32'hFFFF_FFFF);
        wr(9'h1FC, 32'hFFFF_FFFF);
        wr(9'h005, 32'hFFFF_FFFF);
        rd(9'h130, d); chk("R9 read 0x130", d, 32'd0);
        rd(9'h1FC, d); chk("R9 read 0x1FC", d, 32'd0);
        rd(9'h005, d); chk("R9 read misaligned", d, 32'd0);
        rd(9'h004, d); chk("R9 mask kept", d, 32'd0);
        rd(slot_addr(63), d); chk("R9 slot63 kept", d, 32'd0);

        // clear slots used above
        wr(slot_addr(5), 32'h0); wr(9'h098, 32'h0); wr(9'h0D0, 32'h0);

        // R3 R4 R5 single source sweep
        set_route(LVL);
        set_mask({64{1'b1}});
        for (int n = 0; n < 64; n++) begin
            int b;
            logic [31:0] bit_w;
            b = n / 32;
            bit_w = 32'd1 << (n % 32);
            @(negedge clk);
            src = 64'd1 << n;
            settle();
            chk($sformatf("R5 irq_o src%0d", n), {31'd0, irq_o}, {31'd0, ~LVL[n]});
            chk($sformatf("R5 fiq_o src%0d", n), {31'd0, fiq_o}, {31'd0, LVL[n]});
            chk($sformatf("R7 wake any src%0d", n), {31'd0, wake_o}, 32'd1);
            rd(bank_base(b) + 9'h010, d);
            chk($sformatf("R3 raw src%0d", n), d, bit_w);
            rd(bank_base(b) + 9'h000, d);
            chk($sformatf("R4 irq pend src%0d", n), d, LVL[n] ? 32'd0 : bit_w);
            rd(bank_base(b) + 9'h00C, d);
            chk($sformatf("R4 fiq pend src%0d", n), d, LVL[n] ? bit_w : 32'd0);
        end

        // R3 writes to status registers ignored
        @(negedge clk);
        src = 64'h0123_4567_89AB_CDEF;
        settle();
        wr(9'h010, 32'h0);
        wr(9'h09C, 32'hFFFF_FFFF);
        wr(9'h0A8, 32'h0);
        wr(9'h018, 32'hFFFF_FFFF);
        rd(9'h010, d); chk("R3 raw bank0 after write", d, src[31:0]);
        rd(9'h0AC, d); chk("R3 raw bank1", d, src[63:32]);
        rd(9'h09C, d); chk("R3 irq pend bank1 after write", d, src[63:32] & ~LVL[63:32]);
        rd(9'h0A8, d); chk("R3 fiq pend bank1 after write", d, src[63:32] & LVL[63:32]);
        rd(9'h018, d); chk("R3 winner after write", d, 32'd0);

        // R4 pending independent of mask, R5 and R7 with all masked
        set_mask('0);
        rd(9'h000, d); chk("R4 irq pend masked", d, src[31:0] & ~LVL[31:0]);
        set_ctrl(1'b1);
        for (int n = 0; n < 64; n++) begin
            @(negedge clk);
            src = 64'd1 << n;
            settle();
            chk($sformatf("R5 masked irq src%0d", n), {31'd0, irq_o}, 32'd0);
            chk($sformatf("R5 masked fiq src%0d", n), {31'd0, fiq_o}, 32'd0);
            chk($sformatf("R7 gated wake src%0d", n), {31'd0, wake_o}, 32'd0);
        end
        set_ctrl(1'b0);
        settle();
        chk("R7 ungated wake", {31'd0, wake_o}, 32'd1);

        // R6 priority table: slot s names (37*s+11) mod 64, every 7th slot invalid
        for (int s = 0; s < 64; s++) begin
            m_sv[s] = ((s % 7) != 3);
            m_ss[s] = 6'((37 * s + 11) % 64);
            wr(slot_addr(s), {m_sv[s], 25'd0, m_ss[s]});
        end
        rd(slot_addr(1), d); chk("R2 slot1 readback", d, 32'h8000_0030);
        rd(slot_addr(3), d); chk("R2 slot3 invalid readback", d, 32'h0000_003A);

        // R6 explicit corners, all routed to IRQ
        set_route('0);
        set_mask({64{1'b1}});
        @(negedge clk); src = 64'd1 << 58;
        settle();
        chk("R6 source on invalid slot irq_o", {31'd0, irq_o}, 32'd1);
        rd(9'h018, d); chk("R6 invalid slot no winner", d, 32'd0);
        @(negedge clk); src = (64'd1 << 58) | (64'd1 << 48);
        settle();
        rd(9'h018, d); chk("R6 slot1 winner", d, {1'b1, 9'd0, 6'd48, 16'h0});
        @(negedge clk); src = (64'd1 << 58) | (64'd1 << 48) | (64'd1 << 11);
        settle();
        rd(9'h018, d); chk("R6 slot0 beats higher number", d, {1'b1, 9'd0, 6'd11, 16'h0});
        set_route(64'd1 << 11);
        settle();
        rd(9'h018, d); chk("R6 FIQ routed skipped", d, {1'b1, 9'd0, 6'd48, 16'h0});

        // R5 R6 R7 pseudo-random patterns
        set_route(LVL);
        x = 64'h9E37_79B9_7F4A_7C15;
        for (int it = 0; it < 160; it++) begin
            logic [63:0] sv;
            logic [63:0] mv;
            x = xs(x); sv = x;
            x = xs(x); sv = sv & x;
            x = xs(x); mv = x;
            if ((it % 16) == 0) set_ctrl(it[4]);
            set_mask(mv);
            @(negedge clk);
            src = sv;
            settle();
            chk("R5 irq_o pattern", {31'd0, irq_o}, {31'd0, |(sv & mv & ~LVL)});
            chk("R5 fiq_o pattern", {31'd0, fiq_o}, {31'd0, |(sv & mv & LVL)});
            chk("R7 wake pattern", {31'd0, wake_o},
                {31'd0, m_ctrl ? |(sv & mv) : |sv});
            rd(9'h018, d);
            chk("R6 winner pattern", d, exp_winner(sv));
        end

        // R6 R5 mask write and source change in the same cycle
        set_mask({64{1'b1}});
        @(negedge clk);
        src = 64'hFFFF_0000_0000_0000;
        settle();
        @(negedge clk);
        wr_en = 1'b1; addr = 9'h004; wr_data = 32'h0000_0800;
        src = 64'h0000_0001_0000_0800;
        @(negedge clk);
        wr_en = 1'b0;
        m_mask = {32'hFFFF_FFFF, 32'h0000_0800};
        settle();
        chk("R5 same-cycle irq_o", {31'd0, irq_o}, {31'd0, |(src & m_mask & ~LVL)});
        rd(9'h018, d);
        chk("R6 same-cycle winner", d, exp_winner(src));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule